// File: doc/BRIEF.md
# Paged scrolling tile map addresser

This block turns the pixel position that the display pipeline is about to draw into the address of the tile-map entry that covers it, together with the pixel's column and row inside that 8x8 tile. It adds an 8-bit horizontal and an 8-bit vertical scroll offset to the screen coordinates, so the visible window can slide over the tile map one pixel at a time. The screen is 32 tiles wide and, depending on the row mode, 24 or 30 tiles high.

Two page-enable bits enlarge the virtual map. With horizontal paging, the window can scroll into a second map placed directly after the first. With vertical paging, a further map sits below. With both bits set, four pages form a 64x60 tile field. A per-pixel fixed request selects a separate tile map that ignores scrolling and paging, for status bars and similar overlays. The address is produced two clock cycles after the position is presented, and the pipeline accepts one position per cycle.

Top module: `tile_map_addresser`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly two clock cycles. Every input sampled with `in_valid` high produces its result in that same output cycle, one result per cycle.
- R2: When `fixed_req` is low, `fine_col` is (pix_x + hscroll) mod 8 and `fine_row` is (pix_y + vscroll) mod 8.
- R3: When `hpage_en` is low, the tile column is ((pix_x + hscroll) div 8) mod 32 and no horizontal page offset is added.
- R4: When `hpage_en` is high, a scrolled tile column of 32 or more selects the right-hand page: column minus 32, plus one page size.
- R5: The rows per page are 24 when `tall_mode` is 0 and 30 when it is 1. When `vpage_en` is low, the scrolled tile row ((pix_y + vscroll) div 8) wraps modulo the rows per page.
- R6: When `vpage_en` is high, the scrolled tile row wraps modulo twice the rows per page. Rows in the upper half select the lower page, whose offset is one page size when `hpage_en` is low and two page sizes when it is high.
- R7: One page size is 32 times the rows per page: 768 entries in short mode and 960 in tall mode.
- R8: `nt_addr` = base + page offset + tile_row*32 + tile_column, truncated to 14 bits.
- R9: When `fixed_req` is high, the scroll offsets and both page bits are ignored. The column, row and fine offsets come from the unscrolled pix_x and pix_y, the base is `fixed_base`, and `fixed_sel` is 1. Otherwise the base is `nt_base` and `fixed_sel` is 0.
- R10: While `rst_n` is low, and at the first sample after reset, `out_valid`, `nt_addr`, `fine_col`, `fine_row` and `fixed_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Position is presented this cycle |
| pix_x | input | 8 | Screen pixel column |
| pix_y | input | 8 | Screen pixel row |
| hscroll | input | 8 | Horizontal scroll in pixels |
| vscroll | input | 8 | Vertical scroll in pixels |
| hpage_en | input | 1 | Enable the second horizontal page |
| vpage_en | input | 1 | Enable the second vertical page |
| tall_mode | input | 1 | 1: 30 rows per page, 0: 24 rows |
| fixed_req | input | 1 | Use the unscrolled fixed tile map for this pixel |
| nt_base | input | 14 | Base address of the scrolling tile map |
| fixed_base | input | 14 | Base address of the fixed tile map |
| out_valid | output | 1 | Result valid |
| nt_addr | output | 14 | Tile-map entry address |
| fine_col | output | 3 | Pixel column inside the tile |
| fine_row | output | 3 | Pixel row inside the tile |
| fixed_sel | output | 1 | Result came from the fixed map |

## Verification
The hardest situation to reach is a scrolled row index that must be wrapped twice. This happens in short mode without vertical paging, when a large pix_y meets a large vscroll and the row index runs past twice 24. The stimulus reaches it by driving pix_y at 239 with vscroll 255, and by sweeping vscroll near the ends of its range in both row modes. A second corner is an address that overflows 14 bits: a high base combined with four-page offsets drives the sum past the top of the address space, so truncation is observed. A back-to-back stream with gaps in `in_valid` checks that consecutive results do not mix.

// File: rtl/tmap_pkg.sv
package tmap_pkg;

  typedef struct packed {
    logic fixed;
    logic hpage;
    logic vpage;
    logic tall;
  } tmap_mode_t;

  // one conditional subtraction of a modulus
  function automatic logic [7:0] wrap_sub(input logic [7:0] v, input logic [7:0] m);
    return (v >= m) ? (v - m) : v;
  endfunction

  // rows per page for the selected row mode
  function automatic logic [7:0] rows_per_page(input logic tall, input int short_rows,
                                               input int tall_rows);
    return tall ? 8'(tall_rows) : 8'(short_rows);
  endfunction

  // entries in one page
  function automatic logic [15:0] page_tiles(input int cols, input logic [7:0] rows);
    return 16'(cols) * {8'd0, rows};
  endfunction

endpackage

// File: rtl/tmap_stage_pos.sv
module tmap_stage_pos
  import tmap_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int FINE_W  = 3,
  parameter int ADDR_W  = 14,
  localparam int COL_W  = COORD_W + 1 - FINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] hscroll,
  input  logic [COORD_W-1:0] vscroll,
  input  logic               hpage_en,
  input  logic               vpage_en,
  input  logic               tall_mode,
  input  logic               fixed_req,
  input  logic [ADDR_W-1:0]  nt_base,
  input  logic [ADDR_W-1:0]  fixed_base,
  output logic               s1_valid,
  output logic [COL_W-1:0]   s1_col,
  output logic [COL_W-1:0]   s1_row,
  output logic [FINE_W-1:0]  s1_fx,
  output logic [FINE_W-1:0]  s1_fy,
  output tmap_mode_t         s1_mode,
  output logic [ADDR_W-1:0]  s1_base
);

  logic [COORD_W-1:0] eff_h, eff_v;
  logic [COORD_W:0]   sum_x, sum_y;

  assign eff_h = fixed_req ? COORD_W'(0) : hscroll;
  assign eff_v = fixed_req ? COORD_W'(0) : vscroll;
  assign sum_x = {1'b0, pix_x} + {1'b0, eff_h};
  assign sum_y = {1'b0, pix_y} + {1'b0, eff_v};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_col   <= '0;
      s1_row   <= '0;
      s1_fx    <= '0;
      s1_fy    <= '0;
      s1_mode  <= '0;
      s1_base  <= '0;
    end else begin
      s1_valid      <= in_valid;
      s1_col        <= sum_x[COORD_W:FINE_W];
      s1_row        <= sum_y[COORD_W:FINE_W];
      s1_fx         <= sum_x[FINE_W-1:0];
      s1_fy         <= sum_y[FINE_W-1:0];
      s1_mode.fixed <= fixed_req;
      s1_mode.hpage <= hpage_en & ~fixed_req;
      s1_mode.vpage <= vpage_en & ~fixed_req;
      s1_mode.tall  <= tall_mode;
      s1_base       <= fixed_req ? fixed_base : nt_base;
    end
  end

  // R9
  fixed_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_req |=> (s1_mode.fixed && !s1_mode.hpage && !s1_mode.vpage));

endmodule

// File: rtl/tmap_stage_addr.sv
module tmap_stage_addr
  import tmap_pkg::*;
#(
  parameter int FINE_W     = 3,
  parameter int ADDR_W     = 14,
  parameter int COL_W      = 6,
  parameter int VIS_COLS   = 32,
  parameter int ROWS_SHORT = 24,
  parameter int ROWS_TALL  = 30,
  localparam int TCOL_W    = $clog2(VIS_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [COL_W-1:0]  s1_col,
  input  logic [COL_W-1:0]  s1_row,
  input  logic [FINE_W-1:0] s1_fx,
  input  logic [FINE_W-1:0] s1_fy,
  input  tmap_mode_t        s1_mode,
  input  logic [ADDR_W-1:0] s1_base,
  output logic              out_valid,
  output logic [ADDR_W-1:0] nt_addr,
  output logic [FINE_W-1:0] fine_col,
  output logic [FINE_W-1:0] fine_row,
  output logic              fixed_sel
);

  logic [7:0]        rows8, span8, raw8, wrap1, wrap2, trow8;
  logic              page_x, page_y;
  logic [TCOL_W-1:0] tcol;
  logic [ADDR_W-1:0] psize, off_x, off_y, row_off, addr_n;

  // vertical wrap: the raw row can exceed the span at most twice
  assign rows8  = rows_per_page(s1_mode.tall, ROWS_SHORT, ROWS_TALL);
  assign span8  = s1_mode.vpage ? (rows8 << 1) : rows8;
  assign raw8   = 8'(s1_row);
  assign wrap1  = wrap_sub(raw8, span8);
  assign wrap2  = wrap_sub(wrap1, span8);
  assign page_y = s1_mode.vpage && (wrap2 >= rows8);
  assign trow8  = page_y ? (wrap2 - rows8) : wrap2;

  // horizontal page: column bit above the visible width
  assign page_x = s1_mode.hpage & s1_col[COL_W-1];
  assign tcol   = s1_col[TCOL_W-1:0];

  assign psize   = ADDR_W'(page_tiles(VIS_COLS, rows8));
  assign off_x   = page_x ? psize : '0;
  assign off_y   = page_y ? (s1_mode.hpage ? (psize << 1) : psize) : '0;
  assign row_off = ADDR_W'(trow8) * ADDR_W'(VIS_COLS);
  assign addr_n  = s1_base + off_x + off_y + row_off + ADDR_W'(tcol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      nt_addr   <= '0;
      fine_col  <= '0;
      fine_row  <= '0;
      fixed_sel <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      nt_addr   <= addr_n;
      fine_col  <= s1_fx;
      fine_row  <= s1_fy;
      fixed_sel <= s1_mode.fixed;
    end
  end

  // R5
  row_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (trow8 < rows8));

  // R3
  no_hpage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_mode.hpage) |-> !page_x);

  // R6
  no_vpage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_mode.vpage) |-> !page_y);

endmodule

// File: rtl/tile_map_addresser.sv
module tile_map_addresser
  import tmap_pkg::*;
#(
  parameter int COORD_W    = 8,
  parameter int FINE_W     = 3,
  parameter int ADDR_W     = 14,
  parameter int VIS_COLS   = 32,
  parameter int ROWS_SHORT = 24,
  parameter int ROWS_TALL  = 30,
  localparam int COL_W     = COORD_W + 1 - FINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] hscroll,
  input  logic [COORD_W-1:0] vscroll,
  input  logic               hpage_en,
  input  logic               vpage_en,
  input  logic               tall_mode,
  input  logic               fixed_req,
  input  logic [ADDR_W-1:0]  nt_base,
  input  logic [ADDR_W-1:0]  fixed_base,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  nt_addr,
  output logic [FINE_W-1:0]  fine_col,
  output logic [FINE_W-1:0]  fine_row,
  output logic               fixed_sel
);

  logic              s1_valid;
  logic [COL_W-1:0]  s1_col, s1_row;
  logic [FINE_W-1:0] s1_fx, s1_fy;
  tmap_mode_t        s1_mode;
  logic [ADDR_W-1:0] s1_base;

  tmap_stage_pos #(
    .COORD_W(COORD_W), .FINE_W(FINE_W), .ADDR_W(ADDR_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_x(pix_x), .pix_y(pix_y), .hscroll(hscroll), .vscroll(vscroll),
    .hpage_en(hpage_en), .vpage_en(vpage_en), .tall_mode(tall_mode),
    .fixed_req(fixed_req), .nt_base(nt_base), .fixed_base(fixed_base),
    .s1_valid(s1_valid), .s1_col(s1_col), .s1_row(s1_row),
    .s1_fx(s1_fx), .s1_fy(s1_fy), .s1_mode(s1_mode), .s1_base(s1_base)
  );

  tmap_stage_addr #(
    .FINE_W(FINE_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .VIS_COLS(VIS_COLS),
    .ROWS_SHORT(ROWS_SHORT), .ROWS_TALL(ROWS_TALL)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_col(s1_col),
    .s1_row(s1_row), .s1_fx(s1_fx), .s1_fy(s1_fy), .s1_mode(s1_mode),
    .s1_base(s1_base), .out_valid(out_valid), .nt_addr(nt_addr),
    .fine_col(fine_col), .fine_row(fine_row), .fixed_sel(fixed_sel)
  );

  // cycles since reset, so that $past never reaches into reset time
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'b00;
    else        warm <= {warm[0], 1'b1};
  end

  // scrolled fine offsets as seen at the input, for the output check
  logic [FINE_W-1:0] in_fine_x, in_fine_y;
  assign in_fine_x = FINE_W'(pix_x + hscroll);
  assign in_fine_y = FINE_W'(pix_y + vscroll);

  // R1
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm[1] |-> (out_valid == $past(in_valid, 2)));

  // R2
  fine_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm[1] && out_valid && !fixed_sel) |->
      (fine_col == $past(in_fine_x, 2) && fine_row == $past(in_fine_y, 2)));

  // R9
  fixed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm[1] && out_valid) |-> (fixed_sel == $past(fixed_req, 2)));

endmodule

// File: tb/tile_map_addresser_tb.sv
module tile_map_addresser_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  pix_x, pix_y, hscroll, vscroll;
  logic        hpage_en, vpage_en, tall_mode, fixed_req;
  logic [13:0] nt_base, fixed_base;
  logic        out_valid;
  logic [13:0] nt_addr;
  logic [2:0]  fine_col, fine_row;
  logic        fixed_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tile_map_addresser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_x(pix_x), .pix_y(pix_y),
    .hscroll(hscroll), .vscroll(vscroll), .hpage_en(hpage_en), .vpage_en(vpage_en),
    .tall_mode(tall_mode), .fixed_req(fixed_req), .nt_base(nt_base),
    .fixed_base(fixed_base), .out_valid(out_valid), .nt_addr(nt_addr),
    .fine_col(fine_col), .fine_row(fine_row), .fixed_sel(fixed_sel)
  );

  // model written from the requirements, in plain integer arithmetic
  function automatic int ref_pack(int x, int y, int hs, int vs, bit hp, bit vp,
                                  bit tall, bit fx, int base, int fbase);
    int col, row, fcx, fcy, rows, span, pc, pr, r, c, idx, addr;
    if (fx) begin
      col = x / 8; row = y / 8; fcx = x % 8; fcy = y % 8;
      hp = 0; vp = 0; base = fbase;
    end else begin
      col = (x + hs) / 8; fcx = (x + hs) % 8;
      row = (y + vs) / 8; fcy = (y + vs) % 8;
    end
    rows = tall ? 30 : 24;
    pc   = hp ? col / 32 : 0;
    c    = col % 32;
    span = vp ? 2 * rows : rows;
    r    = row % span;
    pr   = r / rows;
    r    = r % rows;
    idx  = hp ? (pr * 2 + pc) : pr;
    addr = (base + idx * 32 * rows + r * 32 + c) % 16384;
    return (addr << 8) | (fcx << 5) | (fcy << 2) | (fx ? 2 : 0) | 1;
  endfunction

  function automatic int dut_pack();
    return (int'(nt_addr) << 8) | (int'(fine_col) << 5) | (int'(fine_row) << 2)
         | (fixed_sel ? 2 : 0) | (out_valid ? 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual addr=%0d fc=%0d fr=%0d fix=%0d v=%0d expected addr=%0d fc=%0d fr=%0d fix=%0d v=%0d",
               req, act >> 8, (act >> 5) & 7, (act >> 2) & 7, (act >> 1) & 1, act & 1,
               exp >> 8, (exp >> 5) & 7, (exp >> 2) & 7, (exp >> 1) & 1, exp & 1);
    end
  endtask

  task automatic set_mode(int hs, int vs, bit hp, bit vp, bit tall, int base, int fbase);
    @(negedge clk);
    hscroll = 8'(hs); vscroll = 8'(vs); hpage_en = hp; vpage_en = vp;
    tall_mode = tall; nt_base = 14'(base); fixed_base = 14'(fbase);
  endtask

  // present one position, sample the result two edges later
  task automatic probe(string req, int x, int y, bit fx);
    int exp;
    @(negedge clk);
    pix_x = 8'(x); pix_y = 8'(y); fixed_req = fx; in_valid = 1'b1;
    exp = ref_pack(x, y, hscroll, vscroll, hpage_en, vpage_en, tall_mode, fx,
                   nt_base, fixed_base);
    @(negedge clk);
    in_valid = 1'b0; fixed_req = 1'b0;
    @(negedge clk);
    check(req, dut_pack(), exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; pix_x = 8'd77; pix_y = 8'd99;
    hscroll = 8'd5; vscroll = 8'd9; hpage_en = 1; vpage_en = 1; tall_mode = 1;
    fixed_req = 0; nt_base = 14'd1234; fixed_base = 14'd0;
    repeat (4) @(negedge clk);
    check("R10 in reset", dut_pack(), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", dut_pack(), 0);
  endtask

  task automatic t_scroll_plain();
    set_mode(0, 0, 0, 0, 0, 0, 0);
    probe("R8 origin", 0, 0, 0);
    set_mode(13, 21, 0, 0, 0, 100, 0);
    probe("R2 fine offsets", 37, 50, 0);
    set_mode(200, 0, 0, 0, 0, 0, 0);
    probe("R3 column wraps mod 32", 250, 8, 0);
  endtask

  task automatic t_hpage();
    set_mode(200, 0, 1, 0, 0, 16, 0);
    probe("R4 right page short", 100, 0, 0);
    set_mode(255, 10, 1, 0, 1, 16, 0);
    probe("R7 right page tall", 255, 30, 0);
    probe("R4 left page", 0, 0, 0);
  endtask

  task automatic t_vwrap();
    set_mode(0, 255, 0, 0, 0, 0, 0);
    probe("R5 double wrap short", 0, 239, 0);
    set_mode(0, 200, 0, 0, 1, 0, 0);
    probe("R5 wrap tall", 9, 100, 0);
    set_mode(0, 0, 0, 0, 0, 0, 0);
    probe("R5 last short row", 255, 191, 0);
  endtask

  task automatic t_vpage();
    set_mode(0, 100, 0, 1, 0, 0, 0);
    probe("R6 lower page, no hpage", 0, 120, 0);
    set_mode(0, 255, 0, 1, 1, 0, 0);
    probe("R6 tall wrap 2x rows", 0, 239, 0);
    set_mode(128, 200, 1, 1, 1, 0, 0);
    probe("R6 four pages", 200, 50, 0);
  endtask

  task automatic t_fixed();
    set_mode(123, 77, 1, 1, 1, 500, 9000);
    probe("R9 fixed ignores scroll", 45, 66, 1);
    probe("R9 scroll resumes", 45, 66, 0);
  endtask

  task automatic t_addr_wrap();
    set_mode(255, 255, 1, 1, 1, 16000, 0);
    probe("R8 address truncation", 250, 230, 0);
  endtask

  task automatic t_stream();
    int exp_q[24];
    set_mode(37, 91, 1, 1, 0, 2048, 300);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (k >= 2)
        check("R1 stream latency", dut_pack(),
              exp_q[k-2] < 0 ? (dut_pack() & ~1) : exp_q[k-2]);
      if (k < 20) begin
        pix_x = 8'(k * 13); pix_y = 8'(k * 11); fixed_req = (k % 5 == 4);
        in_valid = (k % 3 != 0);
        exp_q[k] = in_valid ? ref_pack(k * 13, k * 11, 37, 91, 1, 1, 0, k % 5 == 4,
                                       2048, 300) : -1;
      end else begin
        in_valid = 1'b0; fixed_req = 1'b0; exp_q[k] = -1;
      end
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_scroll_plain();
        t_hpage();
        t_vwrap();
        t_vpage();
        t_fixed();
        t_addr_wrap();
        t_stream();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule